// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Aggregator

This block gathers up to 32 interrupt request lines into a single interrupt to a processor. Software picks one of four trigger types for each line, from two bits: a mode bit (edge or level) and a polarity bit (active-high or active-low). Each line is resynchronised into the local clock. The block records each qualifying event as a pending bit and gates the pending bits with a per-line enable mask. It then drives one combined interrupt pin. Software picks whether that pin is a steady level or a single-cycle pulse, and which polarity it has.

Software reaches the block through a plain synchronous 32-bit register port with a byte address. A write is taken on any rising clock edge while `wr_en` is high. Read data is combinational from `addr`. The port has no back-pressure: every write is accepted in the cycle it is presented. A force register lets software inject a pending event on any line. Pending edge events are acknowledged by writing ones to the status register.

Top module: `irq_aggregator`

## Requirements
- R1: Register offsets are: enable 0x00, status 0x04, line mode 0x08, line polarity 0x0C, output mode 0x10 (bit 0 only), output polarity 0x14 (bit 0 only), force 0x18. Enable, mode and polarity registers read back what was written. The upper 31 bits of the two output registers read as zero. The force register and every unmapped address read as zero.
- R2: After reset, enable, line mode, line polarity, output mode and output polarity all read zero, and `irq_o` is high (deasserted, because output polarity 0 means active-low).
- R3: A line whose mode bit is 1 is edge-sensed. Polarity 1 latches its status bit on a 0-to-1 transition and polarity 0 latches it on a 1-to-0 transition. The opposite transition sets nothing. A latched bit stays set until it is acknowledged.
- R4: A line whose mode bit is 0 is level-sensed. Its status bit equals the line's active level (high for polarity 1, low for polarity 0). Writing 1 to that status bit has no effect, and the bit falls once the line goes inactive.
- R5: Writing 1 to a status bit of an edge-sensed line clears it. Writing 0 leaves it unchanged.
- R6: An enable bit of 0 keeps the line from affecting `irq_o` but keeps its status bit. Setting the enable bit later lets the held event reach `irq_o`.
- R7: Writing 1 to a force bit makes the matching status bit read 1 right after the write. On an edge-sensed line the bit stays set until it is acknowledged. On an inactive level-sensed line it drops one cycle later.
- R8: With output mode 0, `irq_o` equals the output polarity bit when any enabled status bit is set, and its complement otherwise. It is updated one clock after the status bit changes.
- R9: With output mode 1, `irq_o` shows the output polarity value for exactly one cycle for each cycle in which an enabled status bit newly becomes set. The rest of the time it shows the complement.
- R10: A change on an input line first appears in the status register after the third rising clock edge following the change (two synchroniser stages, then the status register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Asynchronous interrupt request lines |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_o | output | 1 | Combined interrupt output |

## Verification
A pending bit that sets, clears or holds wrongly shows in the status register within three clocks of the input change that should have set it. It also shows on `irq_o` one clock after that. A broken synchroniser or edge detector moves the first appearance of a status bit away from the third edge, or sets it on the wrong transition. A fault in the output stage shows up as a pulse that lasts more than one cycle, or as a missing pulse, or as a level that ignores the enable mask. Any of these is visible within a few cycles of the event.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    SEL_EN, SEL_STAT, SEL_SMODE, SEL_SPOL, SEL_OMODE, SEL_OPOL, SEL_FORCE, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      8'h00:   return SEL_EN;
      8'h04:   return SEL_STAT;
      8'h08:   return SEL_SMODE;
      8'h0C:   return SEL_SPOL;
      8'h10:   return SEL_OMODE;
      8'h14:   return SEL_OPOL;
      8'h18:   return SEL_FORCE;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqa_sync.sv
module irqa_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/irqa_pending.sv
module irqa_pending #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] smode,
  input  logic [W-1:0] spol,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] force_set,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev_q;
  logic [W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    logic lvl_act;
    logic edg;
    assign lvl_act = spol[i] ? smp[i] : ~smp[i];
    assign edg     = spol[i] ? (smp[i] & ~prev_q[i]) : (~smp[i] & prev_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_q[i] <= 1'b0;
      else if (smode[i]) stat_q[i] <= edg | force_set[i] | (stat_q[i] & ~clr[i]);
      else               stat_q[i] <= lvl_act | force_set[i];
    end

    assert_level_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!smode[i] && lvl_act) |=> stat_q[i]);
    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (smode[i] && stat_q[i] && !clr[i]) |=> stat_q[i]);
    assert_edge_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (smode[i] && clr[i] && !edg && !force_set[i]) |=> !stat_q[i]);
    assert_force_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      force_set[i] |=> stat_q[i]);
  end

  assign stat = stat_q;
endmodule

// File: rtl/irqa_outgen.sv
module irqa_outgen #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] en,
  input  logic         omode,
  input  logic         opol,
  output logic         irq
);
  logic [W-1:0] masked;
  logic [W-1:0] prev_masked_q;
  logic         fresh;
  logic         any_set;
  logic         active;
  logic         irq_q;

  assign masked  = stat & en;
  assign fresh   = |(masked & ~prev_masked_q);
  assign any_set = |masked;
  assign active  = omode ? fresh : any_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_masked_q <= '0;
      irq_q         <= 1'b1;
    end else begin
      prev_masked_q <= masked;
      irq_q         <= opol ? active : ~active;
    end
  end

  assign irq = irq_q;

  assert_level_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!omode && !any_set) |=> (irq_q != $past(opol)));
  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(omode) && irq_q == $past(opol)) |-> (prev_masked_q != '0));
endmodule

// File: rtl/irqa_regs.sv
module irqa_regs
  import irqa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [W-1:0]      stat,
  output logic [DATA_W-1:0] rdata,
  output logic [W-1:0]      en,
  output logic [W-1:0]      smode,
  output logic [W-1:0]      spol,
  output logic              omode,
  output logic              opol,
  output logic [W-1:0]      clr,
  output logic [W-1:0]      force_set
);
  reg_sel_e sel;
  assign sel = decode_addr(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0; smode <= '0; spol <= '0; omode <= 1'b0; opol <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_EN:    en    <= wdata[W-1:0];
        SEL_SMODE: smode <= wdata[W-1:0];
        SEL_SPOL:  spol  <= wdata[W-1:0];
        SEL_OMODE: omode <= wdata[0];
        SEL_OPOL:  opol  <= wdata[0];
        default:   ;
      endcase
    end
  end

  assign clr       = (wr_en && sel == SEL_STAT)  ? wdata[W-1:0] : '0;
  assign force_set = (wr_en && sel == SEL_FORCE) ? wdata[W-1:0] : '0;

  always_comb begin
    case (sel)
      SEL_EN:    rdata = DATA_W'(en);
      SEL_STAT:  rdata = DATA_W'(stat);
      SEL_SMODE: rdata = DATA_W'(smode);
      SEL_SPOL:  rdata = DATA_W'(spol);
      SEL_OMODE: rdata = DATA_W'(omode);
      SEL_OPOL:  rdata = DATA_W'(opol);
      default:   rdata = '0;
    endcase
  end

  assert_out_regs_narrow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_OMODE || sel == SEL_OPOL) |-> (rdata[DATA_W-1:1] == '0));
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_EN) |=> (en == $past(wdata[W-1:0])));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqa_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] smp, stat, en, smode, spol, clr, force_set;
  logic               omode, opol;

  irqa_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(src_i), .dout(smp));

  irqa_regs #(.W(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .stat(stat), .rdata(rdata), .en(en), .smode(smode), .spol(spol),
    .omode(omode), .opol(opol), .clr(clr), .force_set(force_set));

  irqa_pending #(.W(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .smp(smp), .smode(smode), .spol(spol),
    .clr(clr), .force_set(force_set), .stat(stat));

  irqa_outgen #(.W(NUM_SRC)) u_out (
    .clk(clk), .rst_n(rst_n), .stat(stat), .en(en), .omode(omode),
    .opol(opol), .irq(irq_o));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  localparam logic [7:0] A_EN = 8'h00, A_ST = 8'h04, A_SM = 8'h08, A_SP = 8'h0C,
                         A_OM = 8'h10, A_OP = 8'h14, A_FO = 8'h18;

  always #5 clk = ~clk;

  irq_aggregator u_dut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_stat(input logic [31:0] m, input logic [31:0] p,
                                           input logic [31:0] o, input logic [31:0] n);
    logic [31:0] act = ~(n ^ p);
    return (~m & act) | (m & (o ^ n) & act);
  endfunction

  function automatic logic exp_irq(input logic [31:0] s, input logic [31:0] e, input logic pol);
    return pol ? |(s & e) : ~|(s & e);
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual running expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, m, p, e, o, n;
    logic        op;
    int          cnt;
    void'($urandom(32'h5EED_1234));
    idle(3); rst_n = 1'b1; idle(1);

    // R2 reset state
    rd(A_EN, d); check("R2 en", d, 0);
    rd(A_SM, d); check("R2 smode", d, 0);
    rd(A_SP, d); check("R2 spol", d, 0);
    rd(A_OM, d); check("R2 omode", d, 0);
    rd(A_OP, d); check("R2 opol", d, 0);
    check("R2 irq idle", 32'(irq_o), 1);

    // R1 map and readback
    wr(A_SP, 32'hA5A5_0F0F); rd(A_SP, d); check("R1 spol rb", d, 32'hA5A5_0F0F);
    wr(A_OM, 32'hFFFF_FFFE); rd(A_OM, d); check("R1 omode narrow", d, 0);
    wr(A_OP, 32'hFFFF_FFFF); rd(A_OP, d); check("R1 opol narrow", d, 1);
    wr(A_FO, 32'h0); rd(A_FO, d); check("R1 force reads 0", d, 0);
    rd(8'h1C, d); check("R1 unmapped 1C", d, 0);
    rd(8'h40, d); check("R1 unmapped 40", d, 0);
    wr(A_OP, 0); wr(A_SP, 0);

    // Random: trigger types vs expected status and level output (R3 R4 R5 R8)
    for (int it = 0; it < 60; it++) begin
      m = $urandom; p = $urandom; e = $urandom; o = $urandom; n = $urandom;
      op = 1'($urandom);
      wr(A_OM, 0); wr(A_SM, m); wr(A_SP, p); wr(A_EN, e); wr(A_OP, 32'(op));
      src_i = o; idle(6);
      wr(A_ST, 32'hFFFF_FFFF); idle(1);
      src_i = n; idle(6);
      rd(A_ST, d); check("R3 R4 random status", d, exp_stat(m, p, o, n));
      check("R8 random irq level", 32'(irq_o), 32'(exp_irq(exp_stat(m, p, o, n), e, op)));
    end

    // R10 latency on an edge line
    src_i = 0; wr(A_SM, 32'h20); wr(A_SP, 32'h20); wr(A_EN, 0); idle(4);
    wr(A_ST, 32'hFFFF_FFFF); addr = A_ST;
    src_i[5] = 1'b1;
    idle(2); #1; check("R10 not yet after 2 edges", 32'(rdata[5]), 0);
    idle(1); #1; check("R10 set after 3 edges", 32'(rdata[5]), 1);

    // R3 falling edge only
    wr(A_SM, 32'h200); wr(A_SP, 0); idle(4); wr(A_ST, 32'hFFFF_FFFF);
    src_i[9] = 1'b1; idle(5); rd(A_ST, d); check("R3 rise ignored on falling line", 32'(d[9]), 0);
    src_i[9] = 1'b0; idle(5); rd(A_ST, d); check("R3 falling latched", 32'(d[9]), 1);
    idle(5); rd(A_ST, d); check("R3 held", 32'(d[9]), 1);

    // R6 mask keeps status, R5 write-one-to-clear
    src_i = 0; wr(A_SM, 32'h0000_0018); wr(A_SP, 32'h0000_0018); wr(A_EN, 0);
    wr(A_OM, 0); wr(A_OP, 1); idle(4); wr(A_ST, 32'hFFFF_FFFF); idle(2);
    src_i[3] = 1'b1; src_i[4] = 1'b1; idle(6);
    check("R6 masked irq low", 32'(irq_o), 0);
    rd(A_ST, d); check("R6 status kept", d & 32'h18, 32'h18);
    wr(A_EN, 32'h8); idle(1); check("R6 enable releases", 32'(irq_o), 1);
    wr(A_ST, 32'h0); rd(A_ST, d); check("R5 zero write no effect", d & 32'h18, 32'h18);
    wr(A_ST, 32'h8); rd(A_ST, d); check("R5 cleared bit3 only", d & 32'h18, 32'h10);
    idle(1); check("R8 irq drops after clear", 32'(irq_o), 0);

    // R4 level clear ineffective while active
    wr(A_SM, 0); wr(A_SP, 32'h80); src_i[7] = 1'b1; idle(5);
    wr(A_ST, 32'h80); rd(A_ST, d); check("R4 clear ignored", 32'(d[7]), 1);
    src_i[7] = 1'b0; idle(5); rd(A_ST, d); check("R4 follows inactive", 32'(d[7]), 0);

    // R7 force
    wr(A_SP, 32'hFFFF_FFFF); src_i = 0; wr(A_SM, 32'h1); idle(4); wr(A_ST, 32'hFFFF_FFFF);
    wr(A_FO, 32'h3); rd(A_ST, d); check("R7 force sets both", d & 32'h3, 32'h3);
    idle(1); rd(A_ST, d); check("R7 edge kept, level dropped", d & 32'h3, 32'h1);

    // R9 pulse mode
    wr(A_ST, 32'hFFFF_FFFF); wr(A_SM, 32'h3); wr(A_SP, 32'h3); wr(A_EN, 32'h3);
    wr(A_OP, 1); wr(A_OM, 1); idle(3);
    check("R9 idle low", 32'(irq_o), 0);
    src_i[0] = 1'b1; cnt = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (irq_o) cnt++; end
    check("R9 one pulse", 32'(cnt), 1);
    src_i[1] = 1'b1; cnt = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (irq_o) cnt++; end
    check("R9 second pulse while pending", 32'(cnt), 1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule